// File: doc/BRIEF.md
# Serial EEPROM Station Address Loader

This block pulls a 32-byte configuration table out of a four-wire serial EEPROM that is organised as sixteen 16-bit words. After a start request it drives chip select, serial clock and serial data-in itself, and samples serial data-out. Every pin state is held for a programmable number of system clocks, so the EEPROM sees a slow bit rate.

For each word address from 0 to 15 the block sends one read command and shifts in sixteen data bits. The table is never stored whole. Each byte is folded into a running XOR over the protected range, and the check byte and the six address bytes are captured as they arrive.

When the last word is in, the block raises `done`. It reports whether the check byte matched. It presents the six-byte station address, which reads as zero unless the check passed. A system uses it once after power-up to recover its network address.

Top module: `mwr_station_reader`

## Requirements
- R1: Out of reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `checksum_ok` are low and `station_addr` is zero.
- R2: A `start` seen while idle begins a read of 16 words. The word address equals the iteration number 0..15, and each word is one frame of `ee_cs` high. Every frame starts and ends with all three driven lines low.
- R3: Within a frame, `ee_di` is presented while `ee_sk` is low and is taken on each rising `ee_sk`. The first ten bits are 0, 1, 1, 0 followed by the 6-bit word address, most significant bit first.
- R4: After the address, the block spends one step with `ee_sk` low and `ee_cs` high. It then gives 16 more rising `ee_sk` edges. `ee_do` is sampled at the end of the low step that follows each rising edge. The first 8 bits, MSB first, form table byte 2n and the next 8 form byte 2n+1, so a frame has exactly 26 rising edges.
- R5: Each pin state lasts a whole multiple of HOLD_CYCLES clocks, and one word frame takes 55 steps. `done` reads high 880·HOLD_CYCLES+1 clocks after the edge that accepted `start`.
- R6: `checksum_ok` is high with `done` only when the XOR of bytes KEY_IDX..CK_IDX-1 (defaults 0 and 30) equals byte CK_IDX (default 31).
- R7: `station_addr` carries bytes SA_IDX..SA_IDX+5 (default 10..15), with byte SA_IDX in bits [7:0]. It is all zero whenever the check failed.
- R8: `busy` is high for the whole read and `done` stays high until the next accepted `start`. A `start` seen while `busy` is ignored and does not change the frames or the completion time.
- R9: `ee_sk` and `ee_di` are never high while `ee_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a table read (taken only when idle) |
| ee_do | input | 1 | Serial data from the EEPROM |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| busy | output | 1 | Read in progress |
| done | output | 1 | Read finished, results valid |
| checksum_ok | output | 1 | Check byte matched the XOR of the protected range |
| station_addr | output | 48 | Six station address bytes, lowest index in bits [7:0]; zero if the check failed |

## Verification
The collision that matters is a fresh `start` arriving while the sequencer is stepping through a read. The bench raises `start` in the middle of a frame. It judges the outcome by three things: the completion count stays exactly 880·HOLD_CYCLES+1, the EEPROM model still sees sixteen frames with addresses 0..15, and each frame carries the expected command bits. Across several computed tables, including all-zero, all-ones and a corrupted check byte, the bench predicts `checksum_ok` and `station_addr` arithmetically.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } mw_pins_t;
endpackage

// File: rtl/mwr_pacer.sv
module mwr_pacer #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mwr_seq.sv
module mwr_seq
  import mwr_pkg::*;
#(
  parameter int HOLD_CYCLES = 4,
  parameter int NUM_WORDS   = 16,
  parameter int ADDR_BITS   = 6,
  localparam int WIDX       = $clog2(NUM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            ee_do,
  output logic            ee_cs,
  output logic            ee_sk,
  output logic            ee_di,
  output logic            busy,
  output logic            word_stb,
  output logic [WIDX-1:0] word_idx,
  output logic [15:0]     word_val,
  output logic            fin
);
  // step plan per word: idle, command slots, gap, data slots, tail
  localparam int CMD_BITS  = 4 + ADDR_BITS;
  localparam int GAP_STEP  = 2 * CMD_BITS + 1;
  localparam int DATA0     = GAP_STEP + 1;
  localparam int END_STEP  = DATA0 + 32;
  localparam int SW        = $clog2(END_STEP + 1);
  localparam logic [SW-1:0] S_ONE  = SW'(1);
  localparam logic [SW-1:0] S_CMDL = SW'(2 * CMD_BITS);
  localparam logic [SW-1:0] S_GAP  = SW'(GAP_STEP);
  localparam logic [SW-1:0] S_D0   = SW'(DATA0);
  localparam logic [SW-1:0] S_END  = SW'(END_STEP);
  localparam logic [SW-1:0] S_LSMP = SW'(END_STEP - 1);
  localparam logic [WIDX-1:0] LASTW = WIDX'(NUM_WORDS - 1);

  function automatic mw_pins_t pins_at(logic [SW-1:0] s, logic [WIDX-1:0] w);
    mw_pins_t p;
    logic [CMD_BITS-1:0] cmd;
    logic [SW-1:0] rel;
    int k;
    p   = '0;
    cmd = {4'b0110, ADDR_BITS'(w)};
    rel = s - S_ONE;
    k   = CMD_BITS - 1 - int'(rel >> 1);
    if (s >= S_ONE && s <= S_CMDL) begin
      p.cs = 1'b1;
      p.sk = rel[0];
      p.di = cmd[k];
    end else if (s == S_GAP) begin
      p.cs = 1'b1;
    end else if (s >= S_D0 && s < S_END) begin
      p.cs = 1'b1;
      p.sk = ~s[0];
    end
    return p;
  endfunction

  logic            run, tick, sample;
  logic [SW-1:0]   step;
  logic [WIDX-1:0] widx;
  logic [15:0]     shreg;
  mw_pins_t        pins;

  mwr_pacer #(.HOLD_CYCLES(HOLD_CYCLES)) u_pacer (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  // SK-low half of a data slot: sample at its last cycle
  assign sample = (step >= S_D0) && (step < S_END) && step[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      step     <= '0;
      widx     <= '0;
      pins     <= '0;
      shreg    <= '0;
      word_stb <= 1'b0;
      word_val <= '0;
      fin      <= 1'b0;
    end else begin
      word_stb <= 1'b0;
      fin      <= 1'b0;
      if (!run) begin
        if (start) begin
          run  <= 1'b1;
          step <= '0;
          widx <= '0;
          pins <= '0;
        end
      end else if (tick) begin
        if (sample) shreg <= {shreg[14:0], ee_do};
        if (sample && step == S_LSMP) begin
          word_stb <= 1'b1;
          word_val <= {shreg[14:0], ee_do};
        end
        if (step == S_END) begin
          step <= '0;
          pins <= '0;
          if (widx == LASTW) begin
            run <= 1'b0;
            fin <= 1'b1;
          end else begin
            widx <= widx + 1'b1;
          end
        end else begin
          step <= step + 1'b1;
          pins <= pins_at(step + 1'b1, widx);
        end
      end
    end
  end

  assign ee_cs    = pins.cs;
  assign ee_sk    = pins.sk;
  assign ee_di    = pins.di;
  assign busy     = run;
  assign word_idx = widx;
endmodule

// File: rtl/mwr_table.sv
module mwr_table #(
  parameter int NUM_WORDS = 16,
  parameter int KEY_IDX   = 0,
  parameter int SA_IDX    = 10,
  parameter int CK_IDX    = 31,
  parameter int SA_LEN    = 6,
  localparam int WIDX     = $clog2(NUM_WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch,
  input  logic                word_stb,
  input  logic [WIDX-1:0]     word_idx,
  input  logic [15:0]         word_val,
  input  logic                fin,
  output logic                done,
  output logic                checksum_ok,
  output logic [8*SA_LEN-1:0] station_addr
);
  logic [7:0] hi_b, lo_b, acc, ckb, fold;
  int         hi_i, lo_i;
  logic [7:0] sa_q [SA_LEN];
  logic [8*SA_LEN-1:0] sa_flat;

  always_comb begin
    hi_b = word_val[15:8];
    lo_b = word_val[7:0];
    hi_i = 2 * int'(word_idx);
    lo_i = hi_i + 1;
    fold = acc;
    if (hi_i >= KEY_IDX && hi_i < CK_IDX) fold = fold ^ hi_b;
    if (lo_i >= KEY_IDX && lo_i < CK_IDX) fold = fold ^ lo_b;
  end

  always_ff @(posedge clk) begin
    if (rst || launch) begin
      acc          <= '0;
      ckb          <= '0;
      done         <= 1'b0;
      checksum_ok  <= 1'b0;
      station_addr <= '0;
    end else begin
      if (word_stb) begin
        acc <= fold;
        if (hi_i == CK_IDX) ckb <= hi_b;
        if (lo_i == CK_IDX) ckb <= lo_b;
      end
      if (fin) begin
        done         <= 1'b1;
        checksum_ok  <= (acc == ckb);
        station_addr <= (acc == ckb) ? sa_flat : '0;
      end
    end
  end

  for (genvar k = 0; k < SA_LEN; k++) begin : g_sa
    always_ff @(posedge clk) begin
      if (rst || launch)                        sa_q[k] <= '0;
      else if (word_stb && hi_i == SA_IDX + k)  sa_q[k] <= hi_b;
      else if (word_stb && lo_i == SA_IDX + k)  sa_q[k] <= lo_b;
    end
    assign sa_flat[8*k +: 8] = sa_q[k];
  end
endmodule

// File: rtl/mwr_station_reader.sv
module mwr_station_reader #(
  parameter int HOLD_CYCLES = 4,
  parameter int NUM_WORDS   = 16,
  parameter int ADDR_BITS   = 6,
  parameter int KEY_IDX     = 0,
  parameter int SA_IDX      = 10,
  parameter int CK_IDX      = 31,
  parameter int SA_LEN      = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                ee_do,
  output logic                ee_cs,
  output logic                ee_sk,
  output logic                ee_di,
  output logic                busy,
  output logic                done,
  output logic                checksum_ok,
  output logic [8*SA_LEN-1:0] station_addr
);
  localparam int WIDX = $clog2(NUM_WORDS);

  logic            word_stb, fin, launch;
  logic [WIDX-1:0] word_idx;
  logic [15:0]     word_val;

  assign launch = start && !busy;

  mwr_seq #(
    .HOLD_CYCLES(HOLD_CYCLES), .NUM_WORDS(NUM_WORDS), .ADDR_BITS(ADDR_BITS)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .busy(busy),
    .word_stb(word_stb), .word_idx(word_idx), .word_val(word_val), .fin(fin)
  );

  mwr_table #(
    .NUM_WORDS(NUM_WORDS), .KEY_IDX(KEY_IDX), .SA_IDX(SA_IDX),
    .CK_IDX(CK_IDX), .SA_LEN(SA_LEN)
  ) u_table (
    .clk(clk), .rst(rst), .launch(launch), .word_stb(word_stb),
    .word_idx(word_idx), .word_val(word_val), .fin(fin),
    .done(done), .checksum_ok(checksum_ok), .station_addr(station_addr)
  );
endmodule

// File: rtl/mwr_station_reader_chk.sv
module mwr_station_reader_chk #(
  parameter int HOLD_CYCLES = 4,
  parameter int SA_LEN      = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                ee_cs,
  input logic                ee_sk,
  input logic                ee_di,
  input logic                busy,
  input logic                done,
  input logic                checksum_ok,
  input logic [8*SA_LEN-1:0] station_addr
);
  logic [2:0] prev_pins;
  int         since;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_pins <= '0;
      since     <= 0;
    end else begin
      prev_pins <= {ee_cs, ee_sk, ee_di};
      if ({ee_cs, ee_sk, ee_di} != prev_pins) since <= 0;
      else if (since < HOLD_CYCLES)           since <= since + 1;
    end
  end

  p_quiet_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ee_cs && !ee_sk && !ee_di && !busy && !done && !checksum_ok));

  p_step_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && {ee_cs, ee_sk, ee_di} != prev_pins) |-> (since >= HOLD_CYCLES - 1));

  p_sk_gated_r9: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> ee_cs);

  p_di_gated_r9: assert property (@(posedge clk) disable iff (rst)
    ee_di |-> ee_cs);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_addr_needs_sum_r7: assert property (@(posedge clk) disable iff (rst)
    (station_addr != '0) |-> checksum_ok);

  p_sum_with_done_r6: assert property (@(posedge clk) disable iff (rst)
    checksum_ok |-> done);
endmodule

bind mwr_station_reader mwr_station_reader_chk #(
  .HOLD_CYCLES(HOLD_CYCLES), .SA_LEN(SA_LEN)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .ee_cs(ee_cs), .ee_sk(ee_sk),
  .ee_di(ee_di), .busy(busy), .done(done), .checksum_ok(checksum_ok),
  .station_addr(station_addr)
);

// File: tb/mwr_station_reader_test.sv
module mwr_station_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 3;
  localparam int NB         = 32;
  localparam int KEY        = 0;
  localparam int SA         = 10;
  localparam int CK         = 31;
  localparam int RUN_CYC    = 880 * HOLD + 1;

  logic clk = 0;
  logic rst = 1;
  logic start = 0;
  logic ee_do = 0;
  logic ee_cs, ee_sk, ee_di, busy, done, checksum_ok;
  logic [47:0] station_addr;

  mwr_station_reader #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst(rst), .start(start), .ee_do(ee_do),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .busy(busy),
    .done(done), .checksum_ok(checksum_ok), .station_addr(station_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // EEPROM model and frame monitor, evaluated at falling clock edges
  logic [7:0] tbl [NB];
  int  cyc = 0, frames = 0, frame_err = 0, hold_err = 0, last_change = -1;
  int  rises = 0, ccnt = 0, dcnt = 0;
  bit  started = 0, outm = 0, prev_sk = 0, prev_cs = 0;
  logic [9:0]  dibits = '0;
  logic [7:0]  cmdsh = '0;
  logic [15:0] wsh = '0;
  logic [2:0]  prevp = '0;

  always @(negedge clk) begin
    cyc++;
    if ({ee_cs, ee_sk, ee_di} != prevp) begin
      if (busy && last_change >= 0 &&
          ((cyc - last_change) < HOLD || ((cyc - last_change) % HOLD) != 0))
        hold_err++;
      if (busy) last_change = cyc;
    end
    prevp = {ee_cs, ee_sk, ee_di};
    if (ee_cs && !prev_cs) begin
      rises = 0;
      dibits = '0;
    end
    if (!ee_cs) begin
      started = 0;
      outm = 0;
      ccnt = 0;
      ee_do = 0;
    end else if (ee_sk && !prev_sk) begin
      rises++;
      if (rises <= 10) dibits = {dibits[8:0], ee_di};
      if (!started) begin
        if (ee_di) started = 1;
        ccnt = 0;
      end else if (!outm) begin
        cmdsh = {cmdsh[6:0], ee_di};
        ccnt++;
        if (ccnt == 8) begin
          outm = 1;
          dcnt = 0;
          wsh = {tbl[2*int'(cmdsh[5:0]) % NB], tbl[(2*int'(cmdsh[5:0]) + 1) % NB]};
          ee_do = 0;
        end
      end else begin
        ee_do = (dcnt < 16) ? wsh[15 - dcnt] : 1'b0;
        dcnt++;
      end
    end
    if (!ee_cs && prev_cs) begin
      if (rises != 26 || dibits != {4'b0110, 6'(frames)}) frame_err++;
      frames++;
    end
    prev_sk = ee_sk;
    prev_cs = ee_cs;
  end

  task automatic run_read(input int seed, input int kind, input bit good,
                          input bit poke);
    logic [7:0] x;
    logic [47:0] exp_sa;
    int n;
    x = 8'h00;
    for (int i = 0; i < NB; i++) begin
      if (kind == 1)      tbl[i] = 8'hFF;
      else if (kind == 2) tbl[i] = 8'h00;
      else                tbl[i] = 8'((seed * 53 + i * i * 7 + i * 29) ^ (seed << (i % 4)));
    end
    for (int i = KEY; i < CK; i++) x = x ^ tbl[i];
    tbl[CK] = good ? x : (x ^ 8'h5A);
    for (int k = 0; k < 6; k++) exp_sa[8*k +: 8] = good ? tbl[SA + k] : 8'h00;
    frames = 0;
    frame_err = 0;
    hold_err = 0;
    last_change = -1;
    @(negedge clk);
    start = 1;
    @(posedge clk);
    n = 0;
    @(negedge clk);
    start = 0;
    while (!done && n < RUN_CYC + 40) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke) start = (n == 200);  // R8: start while busy must be ignored
    end
    start = 0;
    if (!done) chk(0, "R8", "watchdog done", 0, 1);
    chk(n == RUN_CYC, "R5", "cycles to done", n, RUN_CYC);
    chk(frames == 16, "R2", "frame count", frames, 16);
    chk(frame_err == 0, "R3", "command frames bad", frame_err, 0);
    chk(hold_err == 0, "R5", "step hold violations", hold_err, 0);
    chk(!busy, "R8", "busy after done", busy, 0);
    chk(checksum_ok == good, "R6", "checksum_ok", checksum_ok, good);
    chk(station_addr == exp_sa, "R7", "station_addr", station_addr, exp_sa);
    if (good) chk(station_addr[7:0] == tbl[SA], "R4", "first station byte order",
                  station_addr[7:0], tbl[SA]);
    repeat (20) @(negedge clk);
    chk(done && checksum_ok == good, "R8", "done held", done, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!ee_cs && !ee_sk && !ee_di, "R1", "pins in reset", {ee_cs, ee_sk, ee_di}, 0);
    @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !checksum_ok, "R1", "status after reset",
        {busy, done, checksum_ok}, 0);
    chk(station_addr == 48'h0, "R1", "station_addr after reset", station_addr, 0);
    chk(!ee_cs && !ee_sk && !ee_di, "R9", "idle pins", {ee_cs, ee_sk, ee_di}, 0);
    run_read(1, 0, 1, 0);
    run_read(2, 0, 1, 1);
    run_read(3, 0, 0, 0);
    run_read(4, 1, 1, 0);
    run_read(5, 2, 1, 0);
    run_read(6, 0, 0, 1);
    run_read(7, 0, 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule